// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent address translations close to the processor. Each slot is tagged with a virtual page number and holds a complete page table entry, not just a frame number, so that permission and status bits come back together with the translation. A lookup checks every slot at once. The response arrives one clock after the request. On a hit the physical address is the cached frame number with the 12-bit page offset of the request appended. On a miss the block raises a walk request carrying the page number, and a hardware table walker later returns an entry that the block installs.

Two maintenance operations keep the cached entries consistent with the tables in memory. The first drops the one entry that belongs to a given page. The second is triggered by a write to the page-table base register and drops every entry. When a new entry arrives, it goes to a free slot if one exists. If every slot is full, the least recently used slot is overwritten. Recency is kept as a full age ranking across all slots.

The slot count is the parameter `NUM_ENTRIES`, which ranges from 16 to 48 and defaults to 32. A page table entry is 32 bits wide. Bits [31:12] hold the frame number, bit 0 is the present flag, and bits [11:1] are attribute bits that the block stores and returns unchanged.

Top module: `tlb_xlate`

## Requirements
- R1: When `lk_valid` is high and a valid slot is tagged with `lk_vaddr[31:12]`, the next cycle shows `rsp_valid=1` and `rsp_hit=1`. In that cycle `rsp_pte` equals the stored entry and `rsp_paddr` equals `{entry[31:12], lk_vaddr[11:0]}`.
- R2: When a lookup finds no matching slot, the next cycle shows `rsp_valid=1`, `rsp_hit=0`, `rsp_pte=0`, `rsp_paddr=0`, `walk_req=1` and `walk_vpn=lk_vaddr[31:12]`. When there is no lookup, `rsp_valid` and `walk_req` are low the next cycle, and both are low after reset.
- R3: A fill (`fill_valid`) whose entry has bit 0 set installs `fill_pte` under `fill_vpn`. If a free slot exists, the entry goes there and no existing translation is disturbed.
- R4: A fill whose entry has bit 0 clear is ignored, and a later lookup of that page still misses.
- R5: A fill for a page that is already cached overwrites that same slot. Later lookups return the new entry, and no other translation is lost.
- R6: When every slot is valid, a fill for a new page replaces the slot that was hit or filled longest ago. A hit makes its slot the most recent.
- R7: `inv_valid` with `inv_vpn` clears only the valid slot tagged with that page. At most one slot ever matches a page.
- R8: `ptbase_wr` clears every slot in one cycle.
- R9: When `inv_valid` or `ptbase_wr` is high in the same cycle as a lookup, that lookup reports a miss. A fill in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |
| ptbase_wr | input | 1 | Page-table base register write strobe (full flush) |
| fill_valid | input | 1 | Entry returned by the walker |
| fill_vpn | input | 20 | Page number of the returned entry |
| fill_pte | input | 32 | Returned page table entry |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address on hit, zero on miss |
| rsp_pte | output | 32 | Cached entry on hit, zero on miss |
| walk_req | output | 1 | Miss: request for the walker |
| walk_vpn | output | 20 | Page number the walker should fetch |

## Verification
The hardest case to reach from the ports is a replacement in a full cache whose victim is decided by recency rather than by fill order. To set it up, the stimulus fills every slot, then hits the oldest entry so that it becomes the newest. It then fills one more page and checks that the second-oldest page is the one that now misses, while the page it just touched and the other pages still hit. Same-cycle collisions are driven explicitly: a lookup arrives together with an invalidate of an unrelated page, and a fill arrives together with an invalidate. This shows that maintenance wins over both.

// File: rtl/tlb_xlt_pkg.sv
package tlb_xlt_pkg;

    localparam int VA_W  = 32;
    localparam int OFS_W = 12;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = 20;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [OFS_W-1:0] ofs_t;

    // Page table entry: frame number, free attribute bits, present flag at bit 0
    typedef struct packed {
        pfn_t             pfn;
        logic [OFS_W-2:0] attr;
        logic             present;
    } pte_t;

    function automatic logic [VA_W-1:0] make_paddr(input pte_t e, input ofs_t ofs);
        return {e.pfn, ofs};
    endfunction

endpackage

// File: rtl/xlt_match.sv
module xlt_match
    import tlb_xlt_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] valid,
    input  vpn_t         tags [N],
    input  vpn_t         key,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/xlt_pick.sv
module xlt_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlt_age.sv
module xlt_age #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);
    localparam logic [IW-1:0] OLDEST = IW'(N - 1);

    // Ages always form a permutation of 0..N-1; 0 is the most recent
    logic [IW-1:0] age_q [N];
    logic [N-1:0]  old_vec;

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) old_vec[i] = (age_q[i] == OLDEST);
        for (int i = N - 1; i >= 0; i--) begin
            if (old_vec[i]) lru_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int j = 0; j < N; j++) begin
                if (IW'(j) == touch_idx)
                    age_q[j] <= '0;
                else if (age_q[j] < age_q[touch_idx])
                    age_q[j] <= age_q[j] + IW'(1);
            end
        end
    end

    // R6: exactly one slot holds the oldest rank
    a_r6_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(old_vec) == 1);

    // R6: a slot just touched is never the next victim
    a_r6_touch_not_victim: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (lru_idx != $past(touch_idx)));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_xlt_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    input  logic        inv_valid,
    input  logic [19:0] inv_vpn,
    input  logic        ptbase_wr,
    input  logic        fill_valid,
    input  logic [19:0] fill_vpn,
    input  logic [31:0] fill_pte,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_paddr,
    output logic [31:0] rsp_pte,
    output logic        walk_req,
    output logic [19:0] walk_vpn
);
    localparam int N  = NUM_ENTRIES;
    localparam int IW = $clog2(N);

    logic [N-1:0] valid_q;
    vpn_t         tag_q [N];
    pte_t         pte_q [N];

    vpn_t lk_vpn;
    ofs_t lk_ofs;
    pte_t fill_e;
    assign lk_vpn = lk_vaddr[31:12];
    assign lk_ofs = lk_vaddr[11:0];
    assign fill_e = fill_pte;

    logic [N-1:0] lk_match, fill_match, inv_match;

    xlt_match #(.N(N)) u_m_lk   (.valid(valid_q), .tags(tag_q), .key(lk_vpn),   .hit(lk_match));
    xlt_match #(.N(N)) u_m_fill (.valid(valid_q), .tags(tag_q), .key(fill_vpn), .hit(fill_match));
    xlt_match #(.N(N)) u_m_inv  (.valid(valid_q), .tags(tag_q), .key(inv_vpn),  .hit(inv_match));

    logic          lk_any, fill_any, free_any;
    logic [IW-1:0] lk_idx, fill_idx, free_idx, lru_idx;

    xlt_pick #(.N(N)) u_p_lk   (.req(lk_match),   .any(lk_any),   .idx(lk_idx));
    xlt_pick #(.N(N)) u_p_fill (.req(fill_match), .any(fill_any), .idx(fill_idx));
    xlt_pick #(.N(N)) u_p_free (.req(~valid_q),   .any(free_any), .idx(free_idx));

    logic          maint, lk_hit, fill_go, touch_en;
    logic [IW-1:0] fill_slot, touch_idx;

    always_comb begin
        maint     = inv_valid | ptbase_wr;
        lk_hit    = lk_valid & lk_any & ~maint;
        fill_go   = fill_valid & fill_e.present & ~maint;
        fill_slot = fill_any ? fill_idx : (free_any ? free_idx : lru_idx);
        touch_en  = fill_go | lk_hit;
        touch_idx = fill_go ? fill_slot : lk_idx;
    end

    xlt_age #(.N(N)) u_age (
        .clk      (clk),
        .rst      (rst),
        .touch_en (touch_en),
        .touch_idx(touch_idx),
        .lru_idx  (lru_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || ptbase_wr) begin
            valid_q <= '0;
        end else begin
            if (inv_valid) valid_q <= valid_q & ~inv_match;
            if (fill_go)   valid_q[fill_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[fill_slot] <= fill_vpn;
            pte_q[fill_slot] <= fill_e;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_pte   <= '0;
            walk_req  <= 1'b0;
            walk_vpn  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_hit;
            rsp_paddr <= lk_hit ? make_paddr(pte_q[lk_idx], lk_ofs) : '0;
            rsp_pte   <= lk_hit ? pte_q[lk_idx] : '0;
            walk_req  <= lk_valid & ~lk_hit;
            walk_vpn  <= lk_valid ? lk_vpn : '0;
        end
    end

    // R7: a page never sits in two slots
    a_r7_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R8: base register write leaves nothing valid
    a_r8_flush_all: assert property (@(posedge clk) disable iff (rst)
        ptbase_wr |=> (valid_q == '0));

    // R4: a non-present entry changes no slot
    a_r4_no_install: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_e.present && !maint) |=> $stable(valid_q));

    // R9: maintenance beats a concurrent lookup
    a_r9_maint_miss: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && maint) |=> (rsp_valid && !rsp_hit));

    // R1: page offset passes through on a hit
    a_r1_offset: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[11:0] == $past(lk_vaddr[11:0])));

    // R2: every miss response asks the walker
    a_r2_walk_on_miss: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> walk_req);

endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        ptbase_wr = 1'b0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [31:0] fill_pte = '0;
    logic        rsp_valid, rsp_hit, walk_req;
    logic [31:0] rsp_paddr, rsp_pte;
    logic [19:0] walk_vpn;

    int checks = 0;
    int fails  = 0;

    bit          exp_hit_q [$];
    logic [31:0] exp_pte_q [$];
    logic [31:0] exp_pa_q  [$];
    logic [19:0] exp_vpn_q [$];
    string       exp_tag_q [$];

    always #2 clk = ~clk;

    tlb_xlate #(.NUM_ENTRIES(32)) u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .ptbase_wr(ptbase_wr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_pte(rsp_pte), .walk_req(walk_req), .walk_vpn(walk_vpn)
    );

    function automatic logic [31:0] pte_of(input logic [19:0] v);
        return {v ^ 20'h5A5A5, 12'h061};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor: pops one expectation per response, half a cycle after the edge
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_hit_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected response: hit=%0b expected no response", rsp_hit);
            end else begin
                automatic bit          eh = exp_hit_q.pop_front();
                automatic logic [31:0] ep = exp_pte_q.pop_front();
                automatic logic [31:0] ea = exp_pa_q.pop_front();
                automatic logic [19:0] ev = exp_vpn_q.pop_front();
                automatic string       et = exp_tag_q.pop_front();
                if (rsp_hit !== eh || rsp_pte !== ep || rsp_paddr !== ea ||
                    walk_req !== !eh || (!eh && walk_vpn !== ev)) begin
                    fails++;
                    $display("FAIL %s: hit=%0b pte=%h pa=%h walk=%0b wvpn=%h expected hit=%0b pte=%h pa=%h walk=%0b wvpn=%h",
                             et, rsp_hit, rsp_pte, rsp_paddr, walk_req, walk_vpn,
                             eh, ep, ea, !eh, ev);
                end
            end
        end
    end

    task automatic expect_lk(input logic [31:0] a, input bit hit,
                             input logic [31:0] pte, input string tag);
        exp_hit_q.push_back(hit);
        exp_pte_q.push_back(hit ? pte : 32'h0);
        exp_pa_q.push_back(hit ? {pte[31:12], a[11:0]} : 32'h0);
        exp_vpn_q.push_back(a[31:12]);
        exp_tag_q.push_back(tag);
    endtask

    task automatic look(input logic [31:0] a, input bit hit,
                        input logic [31:0] pte, input string tag);
        lk_valid = 1'b1;
        lk_vaddr = a;
        expect_lk(a, hit, pte, tag);
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [31:0] pte);
        fill_valid = 1'b1;
        fill_vpn   = v;
        fill_pte   = pte;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [19:0] v);
        inv_valid = 1'b1;
        inv_vpn   = v;
        @(posedge clk); #1;
        inv_valid = 1'b0;
    endtask

    task automatic flush();
        ptbase_wr = 1'b1;
        @(posedge clk); #1;
        ptbase_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R2: idle outputs after reset
        checks++;
        if (rsp_valid !== 1'b0 || walk_req !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset: rsp_valid=%0b walk_req=%0b expected 0 0", rsp_valid, walk_req);
        end
        @(posedge clk); #1;

        // R2: cold miss
        look(32'h0000_1234, 1'b0, 32'h0, "R2 cold miss");
        // R3 / R1: install then hit
        fill(20'h00001, 32'hABCDE061);
        look(32'h0000_1234, 1'b1, 32'hABCDE061, "R1 R3 hit after fill");
        // R4: non-present entry ignored
        fill(20'h00002, 32'h12345060);
        look(32'h0000_2008, 1'b0, 32'h0, "R4 not installed");
        // R5: overwrite in place
        fill(20'h00001, 32'h11111003);
        look(32'h0000_1FFF, 1'b1, 32'h11111003, "R5 overwrite");

        // R6: fill the remaining 31 slots, oldest is now page 1
        for (int i = 0; i < 31; i++) fill(20'h00100 + 20'(i), pte_of(20'h00100 + 20'(i)));
        look(32'h0000_1004, 1'b1, 32'h11111003, "R6 refresh oldest");
        fill(20'h00200, pte_of(20'h00200));
        look(32'h0010_0000, 1'b0, 32'h0, "R6 LRU victim evicted");
        look(32'h0000_1004, 1'b1, 32'h11111003, "R6 refreshed survives");
        look(32'h0010_1ABC, 1'b1, pte_of(20'h00101), "R6 other survives");
        look(32'h0020_0777, 1'b1, pte_of(20'h00200), "R6 new entry");

        // R7: single-page invalidate
        inval(20'h00101);
        look(32'h0010_1000, 1'b0, 32'h0, "R7 invalidated");
        look(32'h0010_2010, 1'b1, pte_of(20'h00102), "R7 neighbour kept");

        // R9: lookup with concurrent invalidate of an unrelated page
        inv_valid = 1'b1;
        inv_vpn   = 20'h00999;
        lk_valid  = 1'b1;
        lk_vaddr  = 32'h0010_3020;
        expect_lk(32'h0010_3020, 1'b0, 32'h0, "R9 lookup vs invalidate");
        @(posedge clk); #1;
        inv_valid = 1'b0;
        lk_valid  = 1'b0;
        look(32'h0010_3020, 1'b1, pte_of(20'h00103), "R9 hit afterwards");
        // R9: fill dropped when maintenance coincides
        inv_valid  = 1'b1;
        inv_vpn    = 20'h00999;
        fill_valid = 1'b1;
        fill_vpn   = 20'h00300;
        fill_pte   = pte_of(20'h00300);
        @(posedge clk); #1;
        inv_valid  = 1'b0;
        fill_valid = 1'b0;
        look(32'h0030_0000, 1'b0, 32'h0, "R9 fill dropped");

        // R8: full flush
        flush();
        look(32'h0000_1004, 1'b0, 32'h0, "R8 flushed page 1");
        look(32'h0020_0004, 1'b0, 32'h0, "R8 flushed page 200");
        fill(20'h00400, pte_of(20'h00400));
        look(32'h0040_0ABC, 1'b1, pte_of(20'h00400), "R3 fill after flush");

        repeat (4) @(posedge clk);
        checks++;
        if (exp_hit_q.size() != 0) begin
            fails++;
            $display("FAIL R1 scoreboard: %0d responses missing, expected 0", exp_hit_q.size());
        end
        summary();
        $finish;
    end

endmodule